// File: doc/BRIEF.md
# PCM Frame Clock Generator

This block derives the timing of a serial voice interface from a fast master clock. It produces a frame sync at the sample rate and a bit clock whose rate depends on the sample coding. Companded 8-bit samples use the base rate. 16-bit two's-complement linear samples use twice that rate. With the default parameters and a 19.2 MHz master clock, the frame sync runs at 8 kHz, and the bit clock runs at 64 kHz (divide by 300) or 128 kHz (divide by 150).

The frame sync has two shapes:
- **Short:** a single bit-clock-wide pulse placed just before the first bit of a frame.
- **Normal (long):** a pulse held high from the first bit of the frame.

A bit-index output tells a neighbouring serializer which bit of the frame is current.

Format and shape requests are sampled only at frame boundaries, so a frame is never cut short or stretched. The bit-clock timer is a state machine with three named states:
- **ST_HALT:** held by reset.
- **ST_BCLK_HI:** first half of a bit period.
- **ST_BCLK_LO:** second half of a bit period.

Its transitions are:
- reset from any state to ST_HALT;
- launch, from ST_HALT to ST_BCLK_HI on the first clock edge with reset low;
- half, from ST_BCLK_HI to ST_BCLK_LO on the last high cycle;
- bit end, from ST_BCLK_LO back to ST_BCLK_HI on the last cycle of a bit period.

Top module: `pcm_frame_clkgen`

## Requirements
- R1: A frame lasts FRAME_DIV master cycles (2400 by default, giving 8 kHz from 19.2 MHz). `bit_idx` returns to 0 at the start of every frame.
- R2: With `fmt_linear` = 0 (companded 8-bit), a frame holds NARROW_BITS bit periods, each of FRAME_DIV/NARROW_BITS cycles (300 by default).
- R3: With `fmt_linear` = 1 (16-bit linear), a frame holds 2×NARROW_BITS bit periods, each of half that length (150 by default).
- R4: Within each bit period of D cycles, `bclk` is high for the first D − D/2 cycles (integer division) and low for the rest. `bclk` therefore rises as each bit begins.
- R5: With `sync_short` = 1, `fsync` is high during exactly the last bit period of a frame, which is one bit clock right before bit 0, and low otherwise.
- R6: With `sync_short` = 0, `fsync` is high from bit 0 through bit 7 in linear mode. In companded mode it is high from bit 0 through bit 6, so that one low bit remains in the frame.
- R7: `bit_idx` counts 0, 1, … up to the last bit of the frame, and steps once per bit period together with the rising `bclk`.
- R8: `fmt_linear` and `sync_short` are sampled only on the clock edge that starts a frame. Changes between those edges have no effect on `bclk`, `fsync` or `bit_idx`. `fmt_active` shows the format currently applied.
- R9: `srst` is synchronous. In any cycle where `srst` is high, `fsync` and `bclk` are low. After a clock edge with `srst` high, `bit_idx` and `fmt_active` are 0. The first frame starts on the first clock edge at which `srst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| srst | input | 1 | Synchronous reset, active high |
| fmt_linear | input | 1 | Requested coding: 0 = companded 8-bit, 1 = 16-bit linear |
| sync_short | input | 1 | Requested sync shape: 0 = normal (long), 1 = short |
| fsync | output | 1 | Frame sync |
| bclk | output | 1 | Bit clock |
| bit_idx | output | IDXW ($clog2(2×NARROW_BITS)) | Index of the current bit within the frame |
| fmt_active | output | 1 | Coding format in force for the current frame |

## Verification
The bench builds two copies of the block and drives both with the same inputs.

The first copy uses FRAME_DIV = 48 and NARROW_BITS = 8. Its bit periods are 6 and 3 cycles, which makes the odd-length duty split of R4 visible. Its 48-cycle frames allow hundreds of boundaries, so the bench can test mid-frame format and shape toggling and reset landing inside a frame.

The second copy keeps the defaults (2400, 8). It confirms the real divide ratios of 300 and 150 over a handful of full frames in each format and shape.

// File: rtl/pcm_fcg_pkg.sv
package pcm_fcg_pkg;

    // Phases of the bit-clock timer
    typedef enum logic [1:0] {
        ST_HALT    = 2'd0,
        ST_BCLK_HI = 2'd1,
        ST_BCLK_LO = 2'd2
    } bclk_state_t;

endpackage

// File: rtl/pcm_fcg_bit_timer.sv
module pcm_fcg_bit_timer
    import pcm_fcg_pkg::*;
#(
    parameter int FRAME_DIV   = 2400,
    parameter int NARROW_BITS = 8
) (
    input  logic clk,
    input  logic srst,
    input  logic wide,
    output logic bclk_raw,
    output logic bit_end,
    output logic launch
);
    localparam int DIV_N  = FRAME_DIV / NARROW_BITS;
    localparam int DIV_W  = DIV_N / 2;
    localparam int HI_N   = DIV_N - DIV_N / 2;
    localparam int HI_W   = DIV_W - DIV_W / 2;
    localparam int PHW    = $clog2(DIV_N);

    bclk_state_t     state_q, state_d;
    logic [PHW-1:0]  phase_q, phase_d;
    logic [PHW-1:0]  last_ph, hi_last;

    always_comb begin
        last_ph = wide ? PHW'(DIV_W - 1) : PHW'(DIV_N - 1);
        hi_last = wide ? PHW'(HI_W - 1)  : PHW'(HI_N - 1);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        unique case (state_q)
            ST_HALT: begin
                state_d = ST_BCLK_HI;
                phase_d = '0;
            end
            ST_BCLK_HI: begin
                if (phase_q == last_ph) begin
                    phase_d = '0;
                end else begin
                    phase_d = phase_q + 1'b1;
                    if (phase_q == hi_last) begin
                        state_d = ST_BCLK_LO;
                    end
                end
            end
            ST_BCLK_LO: begin
                if (phase_q == last_ph) begin
                    state_d = ST_BCLK_HI;
                    phase_d = '0;
                end else begin
                    phase_d = phase_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_HALT;
                phase_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (srst) begin
            state_q <= ST_HALT;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // Outputs
    always_comb begin
        bclk_raw = (state_q == ST_BCLK_HI);
        launch   = (state_q == ST_HALT);
        bit_end  = (state_q != ST_HALT) && (phase_q == last_ph);
    end

endmodule

// File: rtl/pcm_fcg_frame_counter.sv
module pcm_fcg_frame_counter #(
    parameter int NARROW_BITS = 8,
    parameter int IDXW        = $clog2(2 * NARROW_BITS)
) (
    input  logic            clk,
    input  logic            srst,
    input  logic            launch,
    input  logic            bit_end,
    input  logic            fmt_req,
    input  logic            short_req,
    output logic [IDXW-1:0] bit_q,
    output logic            wide_q,
    output logic            short_q
);
    logic [IDXW-1:0] last_bit;

    always_comb begin
        last_bit = wide_q ? IDXW'(2 * NARROW_BITS - 1) : IDXW'(NARROW_BITS - 1);
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            bit_q   <= '0;
            wide_q  <= 1'b0;
            short_q <= 1'b0;
        end else if (launch) begin
            bit_q   <= '0;
            wide_q  <= fmt_req;
            short_q <= short_req;
        end else if (bit_end) begin
            if (bit_q == last_bit) begin
                bit_q   <= '0;
                wide_q  <= fmt_req;
                short_q <= short_req;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pcm_fcg_sync_shaper.sv
module pcm_fcg_sync_shaper #(
    parameter int NARROW_BITS = 8,
    parameter int IDXW        = $clog2(2 * NARROW_BITS)
) (
    input  logic            running,
    input  logic [IDXW-1:0] bit_q,
    input  logic            wide_q,
    input  logic            short_q,
    output logic            fsync_raw
);
    logic [IDXW-1:0] last_bit;
    logic [IDXW-1:0] long_end;

    always_comb begin
        last_bit  = wide_q ? IDXW'(2 * NARROW_BITS - 1) : IDXW'(NARROW_BITS - 1);
        long_end  = wide_q ? IDXW'(NARROW_BITS)         : IDXW'(NARROW_BITS - 1);
        fsync_raw = running && (short_q ? (bit_q == last_bit) : (bit_q < long_end));
    end

endmodule

// File: rtl/pcm_frame_clkgen.sv
module pcm_frame_clkgen #(
    parameter int FRAME_DIV   = 2400,
    parameter int NARROW_BITS = 8,
    localparam int IDXW       = $clog2(2 * NARROW_BITS)
) (
    input  logic            clk,
    input  logic            srst,
    input  logic            fmt_linear,
    input  logic            sync_short,
    output logic            fsync,
    output logic            bclk,
    output logic [IDXW-1:0] bit_idx,
    output logic            fmt_active
);
    logic            bclk_raw, fsync_raw, bit_end, launch;
    logic [IDXW-1:0] bit_q;
    logic            wide_q, short_q;

    pcm_fcg_bit_timer #(
        .FRAME_DIV  (FRAME_DIV),
        .NARROW_BITS(NARROW_BITS)
    ) u_timer (
        .clk     (clk),
        .srst    (srst),
        .wide    (wide_q),
        .bclk_raw(bclk_raw),
        .bit_end (bit_end),
        .launch  (launch)
    );

    pcm_fcg_frame_counter #(
        .NARROW_BITS(NARROW_BITS),
        .IDXW       (IDXW)
    ) u_frame (
        .clk      (clk),
        .srst     (srst),
        .launch   (launch),
        .bit_end  (bit_end),
        .fmt_req  (fmt_linear),
        .short_req(sync_short),
        .bit_q    (bit_q),
        .wide_q   (wide_q),
        .short_q  (short_q)
    );

    pcm_fcg_sync_shaper #(
        .NARROW_BITS(NARROW_BITS),
        .IDXW       (IDXW)
    ) u_sync (
        .running  (!launch),
        .bit_q    (bit_q),
        .wide_q   (wide_q),
        .short_q  (short_q),
        .fsync_raw(fsync_raw)
    );

    always_comb begin
        fsync      = !srst && fsync_raw;
        bclk       = !srst && bclk_raw;
        bit_idx    = bit_q;
        fmt_active = wide_q;
    end

endmodule

// File: rtl/pcm_fcg_checker.sv
module pcm_fcg_checker #(
    parameter int NARROW_BITS = 8,
    parameter int IDXW        = 4
) (
    input logic            clk,
    input logic            srst,
    input logic            fsync,
    input logic            bclk,
    input logic [IDXW-1:0] bit_idx,
    input logic            fmt_active,
    input logic            short_act
);
    logic pv = 1'b0;

    always_ff @(posedge clk) begin
        pv <= !srst;
    end

    a_r7_idx_range: assert property (@(posedge clk) disable iff (srst)
        int'(bit_idx) <= (fmt_active ? 2 * NARROW_BITS - 1 : NARROW_BITS - 1));

    a_r8_fmt_at_boundary: assert property (@(posedge clk) disable iff (srst || !pv)
        (fmt_active != $past(fmt_active)) |-> (bit_idx == '0));

    a_r4_rise_with_bit: assert property (@(posedge clk) disable iff (srst || !pv)
        (bit_idx != $past(bit_idx)) |-> (bclk && !$past(bclk)));

    a_r5_short_last_bit: assert property (@(posedge clk) disable iff (srst)
        (short_act && fsync) |->
        (int'(bit_idx) == (fmt_active ? 2 * NARROW_BITS - 1 : NARROW_BITS - 1)));

    a_r6_long_at_first_bit: assert property (@(posedge clk) disable iff (srst)
        (!short_act && bclk && bit_idx == '0) |-> fsync);

endmodule

bind pcm_frame_clkgen pcm_fcg_checker #(
    .NARROW_BITS(NARROW_BITS),
    .IDXW       (IDXW)
) u_chk (
    .clk       (clk),
    .srst      (srst),
    .fsync     (fsync),
    .bclk      (bclk),
    .bit_idx   (bit_idx),
    .fmt_active(fmt_active),
    .short_act (short_q)
);

// File: tb/pcm_frame_clkgen_tb.sv
module pcm_frame_clkgen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 8;
    localparam int WATCH      = 150000;

    logic clk = 1'b0;
    logic srst = 1'b1;
    logic fmt_linear = 1'b0;
    logic sync_short = 1'b0;

    logic       fs [2];
    logic       bc [2];
    logic       fa [2];
    logic [3:0] bi [2];

    int vecs = 0;
    int miss = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_frame_clkgen #(.FRAME_DIV(48), .NARROW_BITS(NB)) u_dut (
        .clk(clk), .srst(srst), .fmt_linear(fmt_linear), .sync_short(sync_short),
        .fsync(fs[0]), .bclk(bc[0]), .bit_idx(bi[0]), .fmt_active(fa[0]));

    pcm_frame_clkgen u_dut_full (
        .clk(clk), .srst(srst), .fmt_linear(fmt_linear), .sync_short(sync_short),
        .fsync(fs[1]), .bclk(bc[1]), .bit_idx(bi[1]), .fmt_active(fa[1]));

    // Behavioural reference: cycles since frame start plus latched modes
    int fdiv [2] = '{48, 2400};
    int cnt  [2] = '{0, 0};
    bit run  [2] = '{1'b0, 1'b0};
    bit fm   [2] = '{1'b0, 1'b0};
    bit sm   [2] = '{1'b0, 1'b0};

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (srst) begin
                run[i] = 1'b0; cnt[i] = 0; fm[i] = 1'b0; sm[i] = 1'b0;
            end else if (!run[i]) begin
                run[i] = 1'b1; cnt[i] = 0; fm[i] = fmt_linear; sm[i] = sync_short;
            end else begin
                cnt[i] = cnt[i] + 1;
                if (cnt[i] == fdiv[i]) begin
                    cnt[i] = 0; fm[i] = fmt_linear; sm[i] = sync_short;
                end
            end
        end
    end

    task automatic cmp(input int inst, input int got, input int exp, input string req);
        vecs++;
        if (got != exp) begin
            miss++;
            $display("FAIL %s inst%0d t=%0t: got %0d expected %0d", req, inst, $time, got, exp);
        end
    endtask

    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!run[i] || srst) begin
                // R9: quiet outputs in reset and in the launch cycle
                cmp(i, bc[i], 0, "R9 bclk");
                cmp(i, fs[i], 0, "R9 fsync");
                cmp(i, bi[i], 0, "R9 bit_idx");
                cmp(i, fa[i], 0, "R9 fmt_active");
            end else begin
                int n, d, b, ph, eb, ef;
                n  = fm[i] ? 2 * NB : NB;
                d  = fdiv[i] / n;
                b  = cnt[i] / d;
                ph = cnt[i] % d;
                eb = (ph < d - d / 2) ? 1 : 0;
                ef = sm[i] ? ((b == n - 1) ? 1 : 0) : ((b < (fm[i] ? NB : NB - 1)) ? 1 : 0);
                cmp(i, bc[i], eb, fm[i] ? "R3/R4 bclk" : "R2/R4 bclk");
                cmp(i, fs[i], ef, sm[i] ? "R5 fsync" : "R6 fsync");
                cmp(i, bi[i], b, (cnt[i] == 0) ? "R1/R7 bit_idx" : "R7 bit_idx");
                cmp(i, fa[i], fm[i], "R8 fmt_active");
            end
        end
    end

    task automatic drive(input bit r, input bit f, input bit s);
        @(negedge clk);
        #1;
        srst = r; fmt_linear = f; sync_short = s;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCH);
        miss++;
        $display("FAIL R1 watchdog: cycles %0d expected below %0d", WATCH, WATCH);
        summary();
    end

    initial begin
        hold(4);
        drive(0, 0, 0); hold(5003);   // R2 R6: companded, normal sync
        drive(0, 1, 0); hold(5011);   // R3 R8: switch to linear mid-frame
        drive(0, 1, 1); hold(5007);   // R5: short sync, linear
        drive(0, 0, 1); hold(5005);   // R5: short sync, companded
        for (int k = 0; k < 400; k++) begin   // R8: toggling between boundaries
            drive(0, (k % 7) < 3, (k % 11) < 5);
        end
        drive(1, 1, 1); hold(3);      // R9: reset inside a frame
        drive(0, 1, 0); hold(5001);   // R9 R1: restart in linear, normal sync
        drive(1, 0, 0); hold(2);
        drive(0, 0, 0); hold(100);
        summary();
    end

endmodule